// File: doc/BRIEF.md
# Speculative Lock Elision Tracker

This block lets a core run a critical section without acquiring its lock. When the core signals entry, the block requests a register checkpoint. It then watches every load and store the core makes inside the section. Stores are held back in a small store buffer that other agents cannot see, and each one raises an exclusive-ownership request for its address. Each load or store sets a per-line access bit in a small line-tracking model. Incoming snoops are checked against those bits. If a conflicting snoop arrives, or a store finds the buffer full, the section fails: the block pulses a rollback request, drops all buffered stores and clears its tracking state.

When the core signals exit and nothing has gone wrong, the block drains the buffered stores on a commit port. It sends them back to back and refuses snoops for the whole drain, so the rest of the system sees the group as one indivisible update. A load that hits a buffered address gets the buffered value forwarded to it.

The controller is a five-state machine:
- IDLE goes to CKPT on `cs_enter`.
- CKPT takes the checkpoint and always goes to SPEC one cycle later.
- SPEC goes to ABORT on a conflict or an overflow. Otherwise it goes to COMMIT on `cs_exit`.
- COMMIT returns to IDLE once the last buffered store has drained, or after one cycle if the buffer is empty.
- ABORT returns to IDLE after one cycle.

Top module: `spec_elide_tracker`

## Requirements
- R1: After reset the block is in IDLE with `core_ready`=0, `ckpt_take`=0, `ckpt_valid`=0, `rollback`=0, `cm_valid`=0 and `snp_ready`=1.
- R2: `cs_enter` in IDLE gives a one-cycle `ckpt_take` pulse in the next cycle, with `core_ready` still 0. One cycle later `core_ready` and `ckpt_valid` are 1. A load or store presented while `core_ready` is 0 is ignored.
- R3: A store accepted in SPEC is not shown on the commit port before exit. In the same cycle it raises `excl_req_valid` with `excl_req_addr` equal to the store address.
- R4: A load or store in SPEC sets the access bit of line `addr[5:2]`. A snoop with `snp_kind`=2'b01 (invalidate) to a line whose bit is set causes `rollback` in the next cycle.
- R5: A snoop with `snp_kind`=2'b10 (exclusive request) to a line whose bit is set also causes `rollback`. These snoops have no effect: a snoop to a line with no bit set, and a snoop with kind 2'b00 or 2'b11.
- R6: A store to an address already buffered overwrites that entry's data and takes no new slot. A store to a new address while all SB_DEPTH (4) slots are in use raises no ownership request and causes `rollback` in the next cycle.
- R7: `cs_exit` in SPEC with no conflict or overflow starts the drain in the next cycle. The buffer is drained on `cm_valid`/`cm_addr`/`cm_data`, one entry per cycle with no gaps, oldest first, and `cm_last` is set on the final entry. `snp_ready` is 0 for every drain cycle, and a snoop offered then causes no rollback.
- R8: `rollback` lasts exactly one cycle and `ckpt_valid` is still 1 during it. In the following cycle `ckpt_valid` is 0 and the block is idle. Buffered stores from the failed section are never committed.
- R9: After a commit, `ckpt_valid` is 0 and every access bit is cleared. A conflicting snoop to a line touched only by the earlier section causes no rollback in a later section.
- R10: A load in SPEC whose address matches a buffered store gives `ld_fwd_hit`=1 and `ld_fwd_data` equal to the latest buffered data, in the same cycle. A load to any other address gives `ld_fwd_hit`=0.
- R11: `cs_exit` with an empty buffer gives one COMMIT cycle with `cm_valid`=0 and `snp_ready`=0, then IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_enter | input | 1 | Core enters a critical section |
| cs_exit | input | 1 | Core leaves the critical section |
| core_ready | output | 1 | Speculative accesses are accepted |
| ld_valid | input | 1 | Core load |
| ld_addr | input | ADDR_W | Load address |
| ld_fwd_hit | output | 1 | Load matched a buffered store |
| ld_fwd_data | output | DATA_W | Forwarded store data |
| st_valid | input | 1 | Core store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| excl_req_valid | output | 1 | Exclusive-ownership request for a buffered store |
| excl_req_addr | output | ADDR_W | Address of that request |
| snp_valid | input | 1 | Incoming snoop |
| snp_kind | input | 2 | 01 invalidate, 10 exclusive request, others benign |
| snp_addr | input | ADDR_W | Snoop address |
| snp_ready | output | 1 | Snoop accepted this cycle (0 while draining) |
| ckpt_take | output | 1 | Take the register checkpoint |
| ckpt_valid | output | 1 | Checkpoint held |
| rollback | output | 1 | Restore checkpoint; section failed |
| cm_valid | output | 1 | Committed store valid |
| cm_addr | output | ADDR_W | Committed store address |
| cm_data | output | DATA_W | Committed store data |
| cm_last | output | 1 | Final store of the commit group |

## Verification
Sections are run in four shapes. The first has stores only, with repeated addresses, which separates coalescing from allocation and shows the drain order. The second mixes loads and stores, which separates forwarding hits from misses. The third sends snoops of all four kinds to touched and untouched lines, so that real conflicts can be told apart from benign traffic. The last has more distinct stores than slots, to find the exact store that overflows. Random sections built from a small address pool reach all four shapes in many interleavings. Directed cases cover the rest: a store offered in the checkpoint cycle, an empty exit, a snoop during the drain, and a snoop in a later section to a line the previous section touched.

// File: rtl/sle_pkg.sv
package sle_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CKPT,
        ST_SPEC,
        ST_COMMIT,
        ST_ABORT
    } sle_state_e;

    localparam logic [1:0] SNP_INVAL = 2'b01;
    localparam logic [1:0] SNP_EXCL  = 2'b10;
endpackage

// File: rtl/sle_access_bits.sv
module sle_access_bits #(
    parameter int NUM_LINES = 16,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              set_a_en,
    input  logic [LINE_W-1:0] set_a_idx,
    input  logic              set_b_en,
    input  logic [LINE_W-1:0] set_b_idx,
    input  logic [LINE_W-1:0] query_idx,
    output logic              query_hit
);
    logic [NUM_LINES-1:0] bits_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic touch;
        assign touch = (set_a_en && set_a_idx == LINE_W'(g))
                    || (set_b_en && set_b_idx == LINE_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bits_q[g] <= 1'b0;
            else if (clear)  bits_q[g] <= 1'b0;
            else if (touch)  bits_q[g] <= 1'b1;
        end
    end

    assign query_hit = bits_q[query_idx];

    // R4: a touched line reports a hit on the following cycle
    a_r4_bit_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_a_en && !clear) |=> bits_q[$past(set_a_idx)]);
endmodule

// File: rtl/sle_store_buf.sv
module sle_store_buf #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_overflow,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    input  logic              drain_en,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0]  vld;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [DEPTH-1:0]  wr_match, look_match;
    logic [CNT_W-1:0]  count;
    logic              wr_any, full;
    logic [IDX_W-1:0]  rd_idx_q;

    always_comb begin
        count = '0;
        for (int i = 0; i < DEPTH; i++) count = count + CNT_W'(vld[i]);
    end

    assign full        = &vld;
    assign wr_any      = |wr_match;
    assign wr_overflow = full && !wr_any;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic              v_q;
        logic [ADDR_W-1:0] a_q;
        logic [DATA_W-1:0] d_q;
        logic              alloc, upd;

        assign wr_match[g]   = v_q && (a_q == wr_addr);
        assign look_match[g] = v_q && (a_q == look_addr);
        assign alloc = wr_en && !wr_any && !full && (count == CNT_W'(g));
        assign upd   = wr_en && wr_match[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                a_q <= '0;
                d_q <= '0;
            end else if (clear) begin
                v_q <= 1'b0;
            end else if (alloc) begin
                v_q <= 1'b1;
                a_q <= wr_addr;
                d_q <= wr_data;
            end else if (upd) begin
                d_q <= wr_data;
            end
        end

        assign vld[g]      = v_q;
        assign ent_addr[g] = a_q;
        assign ent_data[g] = d_q;
    end

    always_comb begin
        look_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (look_match[i]) look_data = look_data | ent_data[i];
    end
    assign look_hit = |look_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_idx_q <= '0;
        else if (clear)     rd_idx_q <= '0;
        else if (drain_en)  rd_idx_q <= rd_idx_q + IDX_W'(1);
    end

    assign rd_valid = vld[rd_idx_q];
    assign rd_last  = rd_valid && (CNT_W'(rd_idx_q) + CNT_W'(1) == count);
    assign rd_addr  = ent_addr[rd_idx_q];
    assign rd_data  = ent_data[rd_idx_q];

    // R6: an allocation never happens with every slot taken
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wr_overflow);
    // R6: at most one entry holds any address
    a_r6_unique_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_match));
endmodule

// File: rtl/spec_elide_tracker.sv
module spec_elide_tracker
    import sle_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int OFF_W     = 2,
    parameter int NUM_LINES = 16,
    parameter int SB_DEPTH  = 4,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_enter,
    input  logic              cs_exit,
    output logic              core_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_fwd_hit,
    output logic [DATA_W-1:0] ld_fwd_data,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              excl_req_valid,
    output logic [ADDR_W-1:0] excl_req_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ready,
    output logic              ckpt_take,
    output logic              ckpt_valid,
    output logic              rollback,
    output logic              cm_valid,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data,
    output logic              cm_last
);
    sle_state_e state_q, state_d;
    logic       ckpt_valid_q;
    logic       in_spec, bit_hit, sb_overflow, look_hit;
    logic       conflict, overflow, abort_now;
    logic       st_accept, ld_accept;
    logic       rd_valid, rd_last, drain_en, finish, clear_all;

    assign in_spec   = (state_q == ST_SPEC);
    assign conflict  = in_spec && snp_valid && bit_hit
                    && (snp_kind == SNP_INVAL || snp_kind == SNP_EXCL);
    assign overflow  = in_spec && st_valid && sb_overflow;
    assign abort_now = conflict || overflow;
    assign st_accept = in_spec && st_valid && !abort_now;
    assign ld_accept = in_spec && ld_valid && !abort_now;
    assign drain_en  = (state_q == ST_COMMIT) && rd_valid;
    assign finish    = (state_q == ST_COMMIT) && (!rd_valid || rd_last);
    assign clear_all = finish || (state_q == ST_ABORT);

    sle_access_bits #(.NUM_LINES(NUM_LINES)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_all),
        .set_a_en  (ld_accept),
        .set_a_idx (ld_addr[OFF_W +: LINE_W]),
        .set_b_en  (st_accept),
        .set_b_idx (st_addr[OFF_W +: LINE_W]),
        .query_idx (snp_addr[OFF_W +: LINE_W]),
        .query_hit (bit_hit)
    );

    sle_store_buf #(.DEPTH(SB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sb (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear_all),
        .wr_en       (st_accept),
        .wr_addr     (st_addr),
        .wr_data     (st_data),
        .wr_overflow (sb_overflow),
        .look_addr   (ld_addr),
        .look_hit    (look_hit),
        .look_data   (ld_fwd_data),
        .drain_en    (drain_en),
        .rd_valid    (rd_valid),
        .rd_last     (rd_last),
        .rd_addr     (cm_addr),
        .rd_data     (cm_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    ckpt_valid_q <= 1'b0;
        else if (state_q == ST_CKPT)   ckpt_valid_q <= 1'b1;
        else if (clear_all)            ckpt_valid_q <= 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_enter) state_d = ST_CKPT;
            ST_CKPT:   state_d = ST_SPEC;
            ST_SPEC:   if (abort_now)    state_d = ST_ABORT;
                       else if (cs_exit) state_d = ST_COMMIT;
            ST_COMMIT: if (finish) state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        core_ready     = in_spec;
        ckpt_take      = (state_q == ST_CKPT);
        rollback       = (state_q == ST_ABORT);
        snp_ready      = (state_q != ST_COMMIT);
        ckpt_valid     = ckpt_valid_q;
        excl_req_valid = st_accept;
        excl_req_addr  = st_addr;
        ld_fwd_hit     = in_spec && ld_valid && look_hit;
        cm_valid       = drain_en;
        cm_last        = drain_en && rd_last;
    end

    // R2: no access is accepted without a held checkpoint
    a_r2_access_needs_ckpt: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_accept || st_accept) |-> ckpt_valid_q);
    // R8: rollback is a single-cycle pulse, then the checkpoint is gone
    a_r8_rollback_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> (!rollback && !ckpt_valid_q));
    // R7: snoops are held off while stores drain
    a_r7_snoop_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> !snp_ready);
    // R3: ownership requests only come from speculation, never during commit
    a_r3_excl_in_spec: assert property (@(posedge clk) disable iff (!rst_n)
        excl_req_valid |-> (core_ready && !cm_valid));
    // R9: the checkpoint is dropped right after the drain completes
    a_r9_ckpt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !ckpt_valid_q);
endmodule

// File: tb/spec_elide_tracker_tb_top.sv
`timescale 1ns/1ps
module spec_elide_tracker_tb_top;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_enter = 0, cs_exit = 0;
    logic ld_valid = 0, st_valid = 0, snp_valid = 0;
    logic [5:0] ld_addr = '0, st_addr = '0, snp_addr = '0;
    logic [15:0] st_data = '0;
    logic [1:0] snp_kind = '0;
    logic core_ready, ld_fwd_hit, excl_req_valid, snp_ready;
    logic ckpt_take, ckpt_valid, rollback, cm_valid, cm_last;
    logic [15:0] ld_fwd_data, cm_data;
    logic [5:0] excl_req_addr, cm_addr;

    int total = 0, bad = 0;
    logic [5:0]  m_addr [DEPTH];
    logic [15:0] m_data [DEPTH];
    int          m_cnt = 0;
    bit          m_bits [16];
    bit          in_sec = 0;

    always #2.5 clk = ~clk;

    spec_elide_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cs_enter(cs_enter), .cs_exit(cs_exit),
        .core_ready(core_ready), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .excl_req_valid(excl_req_valid), .excl_req_addr(excl_req_addr),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .snp_ready(snp_ready), .ckpt_take(ckpt_take), .ckpt_valid(ckpt_valid),
        .rollback(rollback), .cm_valid(cm_valid), .cm_addr(cm_addr),
        .cm_data(cm_data), .cm_last(cm_last)
    );

    function automatic int line_of(input logic [5:0] a);
        return int'(a[5:2]);
    endfunction

    function automatic bit conflict_kind(input logic [1:0] k);
        return (k == 2'b01) || (k == 2'b10);
    endfunction

    function automatic int find_entry(input logic [5:0] a);
        for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cs_enter = 0; cs_exit = 0; ld_valid = 0; st_valid = 0; snp_valid = 0;
    endtask

    task automatic model_clear();
        m_cnt = 0;
        for (int i = 0; i < 16; i++) m_bits[i] = 0;
        in_sec = 0;
    endtask

    task automatic enter();
        chk("R2 not ready before enter", core_ready, 0);
        cs_enter = 1;
        step();
        chk("R2 ckpt_take pulse", ckpt_take, 1);
        chk("R2 not ready in checkpoint cycle", core_ready, 0);
        step();
        chk("R2 ready after checkpoint", core_ready, 1);
        chk("R2 checkpoint valid", ckpt_valid, 1);
        chk("R2 ckpt_take one cycle", ckpt_take, 0);
        in_sec = 1;
    endtask

    task automatic do_store(input logic [5:0] a, input logic [15:0] d);
        int  e;
        bit  ovf;
        e   = find_entry(a);
        ovf = (e < 0) && (m_cnt == DEPTH);
        st_valid = 1; st_addr = a; st_data = d;
        #1;
        chk(ovf ? "R6 no ownership request on overflow" : "R3 ownership request",
            excl_req_valid, !ovf);
        if (!ovf) chk("R3 ownership address", excl_req_addr, a);
        chk("R3 store invisible", cm_valid, 0);
        step();
        if (ovf) begin
            chk("R6 overflow rollback", rollback, 1);
            chk("R8 checkpoint held during rollback", ckpt_valid, 1);
            step();
            chk("R8 rollback one cycle", rollback, 0);
            chk("R8 checkpoint dropped", ckpt_valid, 0);
            model_clear();
        end else begin
            chk("R6 no rollback on accepted store", rollback, 0);
            if (e >= 0) m_data[e] = d;
            else begin
                m_addr[m_cnt] = a; m_data[m_cnt] = d; m_cnt++;
            end
            m_bits[line_of(a)] = 1;
        end
    endtask

    task automatic do_load(input logic [5:0] a);
        int e;
        e = find_entry(a);
        ld_valid = 1; ld_addr = a;
        #1;
        chk("R10 forward hit", ld_fwd_hit, e >= 0);
        if (e >= 0) chk("R10 forward data", ld_fwd_data, m_data[e]);
        step();
        m_bits[line_of(a)] = 1;
    endtask

    task automatic do_snoop(input logic [5:0] a, input logic [1:0] k);
        bit exp;
        exp = m_bits[line_of(a)] && conflict_kind(k);
        snp_valid = 1; snp_addr = a; snp_kind = k;
        #1;
        chk("R4 snoop accepted in speculation", snp_ready, 1);
        step();
        if (k == 2'b01) chk("R4 invalidate conflict", rollback, exp);
        else            chk("R5 snoop kind/line decision", rollback, exp);
        if (exp) begin
            step();
            chk("R8 checkpoint dropped after conflict", ckpt_valid, 0);
            chk("R8 back to idle", core_ready, 0);
            model_clear();
        end
    endtask

    task automatic do_exit(input bit snoop_in_drain);
        cs_exit = 1;
        step();
        if (m_cnt == 0) begin
            chk("R11 empty commit no store", cm_valid, 0);
            chk("R11 snoops stalled", snp_ready, 0);
            step();
        end else begin
            for (int i = 0; i < m_cnt; i++) begin
                chk("R7 snoop stall", snp_ready, 0);
                chk("R7 commit valid", cm_valid, 1);
                chk("R7 commit address", cm_addr, m_addr[i]);
                chk("R7 commit data", cm_data, m_data[i]);
                chk("R7 commit last", cm_last, i == m_cnt - 1);
                if (snoop_in_drain) begin
                    snp_valid = 1; snp_addr = m_addr[i]; snp_kind = 2'b10;
                end
                step();
            end
        end
        chk("R7 no rollback from commit", rollback, 0);
        chk("R7 drain ends", cm_valid, 0);
        chk("R9 checkpoint dropped after commit", ckpt_valid, 0);
        chk("R9 snoops accepted again", snp_ready, 1);
        model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'd2024));
        model_clear();
        repeat (3) @(negedge clk);
        chk("R1 reset core_ready", core_ready, 0);
        chk("R1 reset ckpt_valid", ckpt_valid, 0);
        rst_n = 1;
        step();
        chk("R1 idle core_ready", core_ready, 0);
        chk("R1 idle ckpt_take", ckpt_take, 0);
        chk("R1 idle ckpt_valid", ckpt_valid, 0);
        chk("R1 idle rollback", rollback, 0);
        chk("R1 idle cm_valid", cm_valid, 0);
        chk("R1 idle snp_ready", snp_ready, 1);

        // R2: store offered during the checkpoint cycle is dropped
        cs_enter = 1;
        step();
        chk("R2 ckpt_take pulse", ckpt_take, 1);
        st_valid = 1; st_addr = 6'h10; st_data = 16'hdead;
        #1;
        chk("R2 ignored store no request", excl_req_valid, 0);
        step();
        chk("R2 ready", core_ready, 1);
        in_sec = 1;
        do_exit(0); // R11: nothing committed

        // coalescing, forwarding, benign snoops, snoop in drain
        enter();
        do_store(6'h04, 16'h1111);
        do_store(6'h08, 16'h2222);
        do_store(6'h04, 16'h3333); // R6 coalesce
        do_load(6'h04);            // R10 hit latest
        do_load(6'h0c);            // R10 miss
        do_snoop(6'h30, 2'b10);    // R5 untouched line
        do_snoop(6'h05, 2'b11);    // R5 benign kind on touched line
        do_snoop(6'h06, 2'b00);    // R5 benign kind
        do_exit(1);                // R7

        // R9: bits cleared after commit
        enter();
        do_snoop(6'h04, 2'b10);
        do_snoop(6'h08, 2'b01);
        do_exit(0);

        // R4 load then invalidate
        enter();
        do_load(6'h20);
        do_snoop(6'h22, 2'b01);
        // R5 store then exclusive request
        enter();
        do_store(6'h28, 16'h4444);
        do_snoop(6'h28, 2'b10);
        // R8 discarded: new section commits nothing
        enter();
        do_exit(0);

        // R6 overflow on the fifth distinct address
        enter();
        for (int i = 0; i < DEPTH; i++) do_store(6'(i * 4), 16'(i + 16'h50));
        do_store(6'h3c, 16'h7777);
        enter();
        do_exit(0);

        // random sections
        for (int s = 0; s < 60; s++) begin
            int n;
            enter();
            n = 1 + $urandom_range(0, 9);
            for (int k = 0; k < n && in_sec; k++) begin
                int r;
                logic [5:0] a;
                r = $urandom_range(0, 99);
                a = 6'($urandom_range(0, 7) * 5);
                if (r < 45)      do_store(a, 16'($urandom));
                else if (r < 75) do_load(a);
                else             do_snoop(a, 2'($urandom_range(0, 3)));
            end
            if (in_sec) do_exit($urandom_range(0, 1) == 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule